// File: doc/BRIEF.md
# Serial Configuration Bitstream Reader

This block is the read-side controller of a serial configuration store that
feeds an FPGA loading itself in master serial mode. The FPGA supplies the
clock; on each rising edge where the chip is selected and output is enabled,
the block presents the next stored bit on a single data line. Bytes are held
in an internal array, and each byte goes out most significant bit first.

The read space is either the whole array or one of four equal quarters picked
by two page-select pins. When the last bit of the chosen region has gone out,
the block releases the data line and pulls its cascade select output low. A
following device in a daisy chain can then take over the shared line. A mode
pin switches the part into programming mode, in which the read path is idle
and a simple byte port fills the array. After power comes up, a ready flag
stays low for a fixed number of clocks.

Top module: `cfg_stream_rd`

## Requirements
- R1: While rst_oe_i is low (with ready_o high and ser_en_i high), each clock edge loads the byte address with the region base and the bit index with 0 and clears the end-of-region state, whatever ce_ni is; data_oe_o is low during that time.
- R2: With ready_o and ser_en_i high, the counters advance and data_oe_o is high only while ce_ni is low and rst_oe_i is high; with ce_ni high the position is held and data_oe_o is low (standby).
- R3: Each byte is sent MSB first, bit 7 down to bit 0; after bit 0 the next byte address follows.
- R4: With page_en_i low, the region spans byte addresses 0 to DEPTH-1.
- R5: With page_en_i high, the region is quarter page_sel_i of the array (0 = lowest addresses, 3 = highest), DEPTH/4 bytes long; base and end are captured when the counters are cleared.
- R6: The edge that shifts out the last bit of the region's last byte ends the stream: data_oe_o goes low and stays low until the next clear.
- R7: ceo_no is low only after the end of the region while ce_ni is low and rst_oe_i is high; it follows ce_ni until rst_oe_i goes low, and it stays high after that until the region has been read through again.
- R8: With ser_en_i low, ce_ni, page_en_i and page_sel_i have no effect: data_oe_o is low, ceo_no is high and the read position is kept for when ser_en_i returns high.
- R9: After rst_ni is released, ready_o stays low for POR_CYCLES clock edges and then stays high; until then the counters are held at the region base and the outputs are idle.
- R10: A byte write through mem_wr_i takes effect only while ser_en_i is low; a write request with ser_en_i high leaves the array unchanged.
- R11: data_o reads 0 whenever data_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock from the FPGA |
| rst_ni | input | 1 | Active-low power-on reset, asynchronous |
| ce_ni | input | 1 | Active-low chip select |
| rst_oe_i | input | 1 | Low: clear counters; high: output enable |
| ser_en_i | input | 1 | High: read mode; low: programming mode |
| page_en_i | input | 1 | High: read one quarter of the array |
| page_sel_i | input | 2 | Quarter number when paging |
| mem_wr_i | input | 1 | Array byte write request |
| mem_addr_i | input | AW | Array byte write address |
| mem_wdata_i | input | 8 | Array byte write data |
| data_o | output | 1 | Serial data bit |
| data_oe_o | output | 1 | Drive enable for data_o |
| ceo_no | output | 1 | Active-low cascade select for the next device |
| ready_o | output | 1 | High once the power-on interval has ended |

## Verification
The sharpest overlap is the edge where the last bit of a region goes out while
chip select or output enable changes on that same edge, or while ser_en_i
drops. End of stream, standby, clear and the programming-mode hold then all
compete for one update. The bench reaches this with full streams whose ends
line up with directed toggles of ce_ni and rst_oe_i, and with long random runs
where those pins move at random moments. On every cycle it compares the
outputs with a reference model that updates in the priority order set by the
requirements: power-on, then programming mode, then clear, then run or hold.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);
  localparam int NUM_PAGES = 4;

  typedef enum logic [2:0] {
    M_POR   = 3'd0,  // power-on interval: hold at base
    M_PROG  = 3'd1,  // programming mode: hold position
    M_CLEAR = 3'd2,  // reset/oe low: reload base
    M_RUN   = 3'd3,  // selected and enabled
    M_HOLD  = 3'd4   // standby
  } rd_mode_e;
endpackage

// File: rtl/cfg_por_timer.sv
module cfg_por_timer #(
  parameter int POR_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  generate
    if (POR_CYCLES == 0) begin : g_none
      logic rdy_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rdy_q <= 1'b0;
        else         rdy_q <= 1'b1;
      end
      assign ready_o = rdy_q;
    end else begin : g_cnt
      localparam int CW = $clog2(POR_CYCLES + 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        cnt_q <= '0;
        else if (cnt_q != CW'(POR_CYCLES))  cnt_q <= cnt_q + 1'b1;
      end
      assign ready_o = (cnt_q == CW'(POR_CYCLES));
    end
  endgenerate
endmodule

// File: rtl/cfg_region_sel.sv
module cfg_region_sel #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          page_en_i,
  input  logic [1:0]    page_sel_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] last_o
);
  import cfg_stream_pkg::*;
  localparam int PAGE = DEPTH / NUM_PAGES;

  generate
    if (DEPTH % NUM_PAGES != 0) begin : g_bad_depth
      $error("DEPTH must be a multiple of four");
    end
  endgenerate

  logic [AW-1:0] base_tbl [NUM_PAGES];
  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    assign base_tbl[p] = AW'(p * PAGE);
  end

  always_comb begin
    if (page_en_i) begin
      base_o = base_tbl[page_sel_i];
      last_o = base_tbl[page_sel_i] + AW'(PAGE - 1);
    end else begin
      base_o = '0;
      last_o = AW'(DEPTH - 1);
    end
  end
endmodule

// File: rtl/cfg_read_counter.sv
module cfg_read_counter #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  cfg_stream_pkg::rd_mode_e            mode_i,
  input  logic [AW-1:0]                       base_i,
  input  logic [AW-1:0]                       last_i,
  output logic [AW-1:0]                       addr_o,
  output logic [cfg_stream_pkg::BIT_IDX_W-1:0] bit_o,
  output logic                                done_o
);
  import cfg_stream_pkg::*;

  logic [AW-1:0]        addr_q, last_q;
  logic [BIT_IDX_W-1:0] bit_q;
  logic                 done_q;
  logic                 byte_end;

  assign byte_end = (bit_q == BIT_IDX_W'(BYTE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      last_q <= AW'(DEPTH - 1);
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      unique case (mode_i)
        M_POR, M_CLEAR: begin
          addr_q <= base_i;
          last_q <= last_i;
          bit_q  <= '0;
          done_q <= 1'b0;
        end
        M_RUN: begin
          if (!done_q) begin
            bit_q <= bit_q + 1'b1;
            if (byte_end) begin
              // region end: keep the address, flag completion
              if (addr_q == last_q) done_q <= 1'b1;
              else                  addr_q <= addr_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign addr_o = addr_q;
  assign bit_o  = bit_q;
  assign done_o = done_q;
endmodule

// File: rtl/cfg_bit_array.sv
module cfg_bit_array #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                                clk_i,
  input  logic                                we_i,
  input  logic [AW-1:0]                       waddr_i,
  input  logic [cfg_stream_pkg::BYTE_W-1:0]    wdata_i,
  input  logic [AW-1:0]                       raddr_i,
  input  logic [cfg_stream_pkg::BIT_IDX_W-1:0] bit_idx_i,
  output logic                                bit_o
);
  import cfg_stream_pkg::*;

  logic [BYTE_W-1:0]    mem_q [DEPTH];
  logic [BYTE_W-1:0]    rd_word;
  logic [BIT_IDX_W-1:0] msb_idx;

  always_ff @(posedge clk_i) begin
    if (we_i && (int'(waddr_i) < DEPTH)) mem_q[waddr_i] <= wdata_i;
  end

  assign rd_word = mem_q[raddr_i];
  assign msb_idx = BIT_IDX_W'(BYTE_W - 1) - bit_idx_i;  // MSB first
  assign bit_o   = rd_word[msb_idx];
endmodule

// File: rtl/cfg_stream_rd.sv
module cfg_stream_rd #(
  parameter  int DEPTH      = 64,
  parameter  int POR_CYCLES = 8,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          rst_oe_i,
  input  logic          ser_en_i,
  input  logic          page_en_i,
  input  logic [1:0]    page_sel_i,
  input  logic          mem_wr_i,
  input  logic [AW-1:0] mem_addr_i,
  input  logic [7:0]    mem_wdata_i,
  output logic          data_o,
  output logic          data_oe_o,
  output logic          ceo_no,
  output logic          ready_o
);
  import cfg_stream_pkg::*;

  logic                 ready;
  rd_mode_e             mode;
  logic [AW-1:0]        base, last, addr;
  logic [BIT_IDX_W-1:0] bit_idx;
  logic                 done, arr_bit;

  cfg_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ready_o(ready)
  );

  cfg_region_sel #(.DEPTH(DEPTH), .AW(AW)) u_region (
    .page_en_i (page_en_i),
    .page_sel_i(page_sel_i),
    .base_o    (base),
    .last_o    (last)
  );

  always_comb begin
    if (!ready)          mode = M_POR;
    else if (!ser_en_i)  mode = M_PROG;
    else if (!rst_oe_i)  mode = M_CLEAR;
    else if (!ce_ni)     mode = M_RUN;
    else                 mode = M_HOLD;
  end

  cfg_read_counter #(.DEPTH(DEPTH), .AW(AW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode),
    .base_i(base),
    .last_i(last),
    .addr_o(addr),
    .bit_o (bit_idx),
    .done_o(done)
  );

  cfg_bit_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
    .clk_i    (clk_i),
    .we_i     (mem_wr_i && !ser_en_i),
    .waddr_i  (mem_addr_i),
    .wdata_i  (mem_wdata_i),
    .raddr_i  (addr),
    .bit_idx_i(bit_idx),
    .bit_o    (arr_bit)
  );

  assign data_oe_o = (mode == M_RUN) && !done;
  assign data_o    = data_oe_o && arr_bit;
  assign ceo_no    = !((mode == M_RUN) && done);
  assign ready_o   = ready;
endmodule

// File: rtl/cfg_stream_rd_chk.sv
module cfg_stream_rd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ce_ni,
  input logic rst_oe_i,
  input logic ser_en_i,
  input logic data_o,
  input logic data_oe_o,
  input logic ceo_no,
  input logic ready_o
);
  a_r1_clear_tristate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_oe_i |-> !data_oe_o);
  a_r2_standby_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> (!data_oe_o && ceo_no));
  a_r7_cascade_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ceo_no |-> !data_oe_o);
  a_r7_clear_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_oe_i && ser_en_i && ready_o) |=> ceo_no);
  a_r8_prog_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_en_i |-> (!data_oe_o && ceo_no));
  a_r9_por_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (!data_oe_o && ceo_no));
  a_r9_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  a_r11_quiet_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> !data_o);
endmodule

bind cfg_stream_rd cfg_stream_rd_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_ni    (ce_ni),
  .rst_oe_i (rst_oe_i),
  .ser_en_i (ser_en_i),
  .data_o   (data_o),
  .data_oe_o(data_oe_o),
  .ceo_no   (ceo_no),
  .ready_o  (ready_o)
);

// File: tb/sim_cfg_stream_rd.sv
module sim_cfg_stream_rd;
  localparam int DEPTH = 64;
  localparam int POR   = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int PAGE  = DEPTH / 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ce_ni = 1'b1, rst_oe_i = 1'b1, ser_en_i = 1'b1, page_en_i = 1'b0;
  logic [1:0] page_sel_i = 2'd0;
  logic mem_wr_i = 1'b0;
  logic [AW-1:0] mem_addr_i = '0;
  logic [7:0] mem_wdata_i = '0;
  logic data_o, data_oe_o, ceo_no, ready_o;

  always #2 clk_i = ~clk_i;

  cfg_stream_rd #(.DEPTH(DEPTH), .POR_CYCLES(POR)) u0 (.*);

  int n_checks = 0, n_fail = 0;
  string cur_req = "R9";

  // reference model state
  logic [7:0] m_mem [DEPTH];
  int m_por = 0, m_addr = 0, m_bit = 0, m_last = DEPTH - 1;
  bit m_done = 0;

  function automatic int base_of(bit pen, logic [1:0] sel);
    return pen ? int'(sel) * PAGE : 0;
  endfunction
  function automatic int last_of(bit pen, logic [1:0] sel);
    return pen ? int'(sel) * PAGE + PAGE - 1 : DEPTH - 1;
  endfunction

  task automatic model_edge();
    bit rdy = (m_por == POR);
    if (!rst_ni) begin
      m_por = 0; m_addr = 0; m_bit = 0; m_done = 0; m_last = DEPTH - 1;
      return;
    end
    if (mem_wr_i && !ser_en_i) m_mem[mem_addr_i] = mem_wdata_i;   // R10
    if (!rdy || (ser_en_i && !rst_oe_i)) begin                     // R9 / R1
      m_addr = base_of(page_en_i, page_sel_i);
      m_last = last_of(page_en_i, page_sel_i);
      m_bit = 0; m_done = 0;
    end else if (ser_en_i && !ce_ni && !m_done) begin              // R2
      if (m_bit == 7) begin
        m_bit = 0;
        if (m_addr == m_last) m_done = 1; else m_addr++;
      end else m_bit++;
    end
    if (m_por < POR) m_por++;
  endtask

  task automatic cmp(string sig, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: act=%0b exp=%0b at %0t", cur_req, sig, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit rdy, run, e_oe, e_ceo, e_dat;
    @(posedge clk_i);
    model_edge();
    #2;
    rdy   = rst_ni && (m_por == POR);
    run   = rdy && ser_en_i && rst_oe_i && !ce_ni;
    e_oe  = run && !m_done;
    e_ceo = !(run && m_done);
    e_dat = e_oe && m_mem[m_addr][7 - m_bit];
    cmp("ready_o", ready_o, rdy);
    cmp("data_oe_o", data_oe_o, e_oe);
    cmp("ceo_no", ceo_no, e_ceo);
    cmp("data_o", data_o, e_dat);
  endtask

  task automatic clear_region(bit pen, logic [1:0] sel);
    page_en_i = pen; page_sel_i = sel; rst_oe_i = 1'b0; ce_ni = 1'b1;
    tick();
    rst_oe_i = 1'b1;
  endtask

  task automatic stream(int n);
    ce_ni = 1'b0;
    repeat (n) tick();
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    // R9: reset state and power-on interval
    cur_req = "R9";
    ce_ni = 1'b0;
    repeat (3) tick();
    rst_ni = 1'b1;
    repeat (POR + 3) tick();
    // R10: preload in programming mode
    cur_req = "R10";
    ser_en_i = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      mem_wr_i = 1'b1; mem_addr_i = AW'(i); mem_wdata_i = 8'($urandom);
      tick();
    end
    m_mem[5] = m_mem[5];
    // R10: write attempt in read mode must be ignored
    ser_en_i = 1'b1; rst_oe_i = 1'b0; ce_ni = 1'b1;
    mem_addr_i = AW'(5); mem_wdata_i = 8'hA5 ^ m_mem[5];
    tick();
    mem_wr_i = 1'b0;
    // R4, R3, R6: full unpaged stream including the address holding 5
    cur_req = "R4";
    clear_region(1'b0, 2'd0);
    cur_req = "R3";
    stream(DEPTH * 8 - 1);
    cur_req = "R6";
    stream(4);
    // R7: cascade follows ce until oe drops
    cur_req = "R7";
    for (int k = 0; k < 6; k++) begin ce_ni = k[0]; tick(); end
    rst_oe_i = 1'b0; ce_ni = 1'b0; tick();
    rst_oe_i = 1'b1; ce_ni = 1'b1; tick();
    ce_ni = 1'b0; repeat (10) tick();
    // R5: each quarter, ending past the boundary
    cur_req = "R5";
    for (int p = 0; p < 4; p++) begin
      clear_region(1'b1, 2'(p));
      page_sel_i = 2'(3 - p);      // later pin change must not move the end
      stream(PAGE * 8 + 3);
    end
    // R2: standby mid-stream holds position
    cur_req = "R2";
    clear_region(1'b0, 2'd0);
    stream(13);
    ce_ni = 1'b1; repeat (5) tick();
    stream(9);
    // R8: programming mode ignores ce and page pins, keeps position
    cur_req = "R8";
    ser_en_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      ce_ni = k[0]; page_en_i = k[1]; page_sel_i = 2'(k); tick();
    end
    ser_en_i = 1'b1; page_en_i = 1'b0;
    stream(20);
    // R1: clear while chip is deselected and while selected
    cur_req = "R1";
    rst_oe_i = 1'b0; ce_ni = 1'b1; tick();
    ce_ni = 1'b0; tick();
    rst_oe_i = 1'b1; stream(12);
    // random mix
    cur_req = "R11";
    for (int k = 0; k < 4000; k++) begin
      ser_en_i  = ($urandom_range(15) != 0);
      rst_oe_i  = ($urandom_range(63) != 0);
      ce_ni     = ($urandom_range(7) == 0);
      if ($urandom_range(127) == 0) begin
        page_en_i = 1'($urandom); page_sel_i = 2'($urandom);
      end
      mem_wr_i    = ($urandom_range(3) == 0);
      mem_addr_i  = AW'($urandom);
      mem_wdata_i = 8'($urandom);
      tick();
    end
    mem_wr_i = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_checks++; n_fail++;
    $display("FAIL R2 watchdog: act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule